// File: doc/BRIEF.md
# RTC Periodic Wakeup Timer

This block generates a periodic wakeup event for a real-time clock domain. Software picks a count clock with a 3-bit source code and loads a 16-bit reload value. The count clock is either the RTC clock (the block's own `clk`) divided by 16, 8, 4 or 2, or a once-per-second calendar strobe that arrives on an input. Once enabled, the timer counts down from the reload value. When it expires it sets a sticky wakeup flag, pulses an interrupt for one cycle and reloads itself, so the events repeat at a fixed period until software disables it.

Two of the strobe-driven source codes stretch the count by 65536 ticks. Wakeup periods of up to 2^17 seconds are then available from a 16-bit reload register. The source code and the reload value may only be changed while a write-allowed status bit reads 1. That bit drops as soon as the timer is enabled. It comes back only after two ticks of the selected count clock have passed since the enable was cleared. While the bit is 0, writes to those two fields are dropped. Software clears the wakeup flag with a one-cycle clear strobe.

Top module: `rtc_wakeup_timer`

## Requirements
- R1: After reset the enable reads 0, the write-allowed bit reads 1, the wakeup flag and the interrupt read 0, the source code reads 0 and the reload value reads 0xFFFF.
- R2: Source codes 0, 1, 2 and 3 tick the timer once every 16, 8, 4 and 2 `clk` cycles respectively. The first interrupt appears (reload+1) x divisor cycles after the clock edge that takes the enable write. Each later interrupt follows the one before it by the same number of cycles.
- R3: Source codes 4 and 5 count the rising-edge-free strobe samples of `sec_tick`, one tick per clock cycle in which `sec_tick` is 1. The timer expires after reload+1 ticks, first counted from the enable write and then between expiries.
- R4: Source codes 6 and 7 count `sec_tick` like codes 4 and 5 but expire after reload+65537 ticks.
- R5: At an expiry the wakeup flag becomes 1 and stays 1. `wake_irq` is 1 for exactly the cycle following the expiring edge. The counter reloads without software action.
- R6: A 1 on `flag_clr` clears the wakeup flag at the next edge. If an expiry occurs at that same edge, the flag stays 1.
- R7: `wr_ok` reads 0 from the edge that sets the enable. After the enable is cleared, it returns to 1 at the second tick of the selected count clock.
- R8: Writes to the source code or the reload value made while `wr_ok` is 0 are ignored. The read-back outputs keep their old values.
- R9: While the enable is 0 the timer does not count and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock, also the source of the divided count clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | Once-per-second calendar strobe, one cycle wide |
| cfg_we | input | 1 | Control write strobe (enable and source code) |
| cfg_en_in | input | 1 | Enable value written by `cfg_we` |
| cfg_sel_in | input | 3 | Source code written by `cfg_we` |
| rld_we | input | 1 | Reload write strobe |
| rld_in | input | 16 | Reload value written by `rld_we` |
| flag_clr | input | 1 | Clears the wakeup flag |
| en_q | output | 1 | Current enable |
| sel_q | output | 3 | Current source code |
| reload_q | output | 16 | Current reload value |
| wr_ok | output | 1 | Source code and reload may be written |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | One-cycle wakeup interrupt pulse |

## Verification
A wrong divider tap or a miscounted reload shows up as an interrupt on the wrong cycle. The first-period timing exposes the error at the very first expiry, (reload+1) ticks after enable, and the spacing between expiries exposes it again one period later. A write-allowed counter that is stuck or too fast shows up as `wr_ok` rising at the wrong strobe after disable. A gating fault in the configuration registers becomes visible on the read-back outputs in the cycle after a rejected write. An error in the flag priority shows on `wake_flag` one edge after a clear strobe that coincides with an expiry.

// File: rtl/rtc_wut_pkg.sv
package rtc_wut_pkg;
   localparam int SEL_W     = 3;
   localparam int DIV_CODES = 4;   // codes 0..3 are clk dividers

   function automatic logic sel_is_div(input logic [SEL_W-1:0] s);
      return !s[2];
   endfunction

   function automatic logic sel_is_ext(input logic [SEL_W-1:0] s);
      return s[2] & s[1];
   endfunction
endpackage

// File: rtl/rtc_wut_tick_gen.sv
module rtc_wut_tick_gen
   import rtc_wut_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   input  logic             sec_tick,
   output logic             tick_o
);
   localparam int PSC_W = DIV_CODES;

   logic [PSC_W-1:0]     psc;
   logic [DIV_CODES-1:0] div_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   psc <= '0;
      else if (run) psc <= psc + 1'b1;
      else          psc <= '0;
   end

   // code c divides by 2^(DIV_CODES-c): tap the low bits of the prescaler
   for (genvar c = 0; c < DIV_CODES; c++) begin : g_tap
      assign div_hit[c] = &psc[DIV_CODES-1-c:0];
   end

   always_comb begin
      if (sel_is_div(sel)) tick_o = div_hit[sel[1:0]];
      else                 tick_o = sec_tick;
   end

   // R2: divided ticks never arrive on two consecutive cycles
   assert_div_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sel_is_div(sel)) |=> (!tick_o || !$stable(sel)));
endmodule

// File: rtl/rtc_wut_sync.sv
module rtc_wut_sync #(
   parameter int SYNC_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   output logic wr_ok
);
   localparam int SC_W = $clog2(SYNC_TICKS + 1);
   localparam logic [SC_W-1:0] SC_FULL = SC_W'(SYNC_TICKS);

   if (SYNC_TICKS < 1) begin : g_chk
      $error("SYNC_TICKS must be at least 1");
   end

   logic [SC_W-1:0] sc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      sc <= SC_FULL;
      else if (enable)                 sc <= '0;
      else if (tick && sc != SC_FULL)  sc <= sc + 1'b1;
   end

   assign wr_ok = !enable && (sc == SC_FULL);

   // R7: write access only reopens on a tick of the selected clock
   assert_wrok_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_ok) |-> $past(tick));
endmodule

// File: rtl/rtc_wut_counter.sv
module rtc_wut_counter #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   input  logic             enable,
   input  logic             tick,
   input  logic             clr,
   output logic             flag,
   output logic             irq
);
   logic [CNT_W-1:0] cnt;
   logic             expire;

   assign expire = enable && tick && (cnt == '0) && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (start)            cnt <= load_val;
      else if (enable && tick)   cnt <= (cnt == '0) ? load_val : cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         irq  <= 1'b0;
      end else begin
         irq <= expire;
         if (expire)   flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end

   // R5: an interrupt always comes with the flag set
   assert_irq_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
   // R6: the flag only drops after a clear strobe
   assert_flag_fall_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr));
   // R9: no interrupt out of a disabled timer
   assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(enable));
endmodule

// File: rtl/rtc_wakeup_timer.sv
module rtc_wakeup_timer
   import rtc_wut_pkg::*;
#(
   parameter int RELOAD_W   = 16,
   parameter int SYNC_TICKS = 2,
   parameter bit HAS_EXT    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sec_tick,
   input  logic                cfg_we,
   input  logic                cfg_en_in,
   input  logic [SEL_W-1:0]    cfg_sel_in,
   input  logic                rld_we,
   input  logic [RELOAD_W-1:0] rld_in,
   input  logic                flag_clr,
   output logic                en_q,
   output logic [SEL_W-1:0]    sel_q,
   output logic [RELOAD_W-1:0] reload_q,
   output logic                wr_ok,
   output logic                wake_flag,
   output logic                wake_irq
);
   localparam int CNT_W = RELOAD_W + 1;

   if (RELOAD_W < 2) begin : g_chk
      $error("RELOAD_W must be at least 2");
   end

   logic [SEL_W-1:0]    sel_nx;
   logic [RELOAD_W-1:0] reload_nx;
   logic [CNT_W-1:0]    load_val;
   logic                start, run, tick, ext;

   assign sel_nx    = (cfg_we && wr_ok) ? cfg_sel_in : sel_q;
   assign reload_nx = (rld_we && wr_ok) ? rld_in : reload_q;
   assign start     = cfg_we && cfg_en_in && !en_q;
   assign run       = en_q || !wr_ok;

   if (HAS_EXT) begin : g_ext
      assign ext = sel_is_ext(sel_nx);
   end else begin : g_noext
      assign ext = 1'b0;
   end
   assign load_val = {ext, reload_nx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         sel_q    <= '0;
         reload_q <= '1;
      end else begin
         if (cfg_we) en_q <= cfg_en_in;
         sel_q    <= sel_nx;
         reload_q <= reload_nx;
      end
   end

   rtc_wut_tick_gen u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q),
      .sec_tick(sec_tick), .tick_o(tick)
   );

   rtc_wut_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
      .clk(clk), .rst_n(rst_n), .enable(en_q), .tick(tick), .wr_ok(wr_ok)
   );

   rtc_wut_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .load_val(load_val),
      .enable(en_q), .tick(tick), .clr(flag_clr),
      .flag(wake_flag), .irq(wake_irq)
   );

   // R8: configuration holds while writes are locked
   assert_sel_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_ok) |-> $stable(sel_q));
   assert_reload_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_ok) |-> $stable(reload_q));
endmodule

// File: tb/tb_rtc_wakeup_timer.sv
module tb_rtc_wakeup_timer;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [2:0]  sel;
      logic [15:0] rld;
      logic [31:0] gap;   // 0: no strobe, g: strobe every g cycles
      logic [31:0] per;   // expected cycles per period
      logic        two;   // also check the second period
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{3'd0, 16'd2, 32'd0, 32'd48,    1'b1},
      '{3'd1, 16'd5, 32'd0, 32'd48,    1'b1},
      '{3'd2, 16'd0, 32'd0, 32'd4,     1'b1},
      '{3'd3, 16'd9, 32'd0, 32'd20,    1'b1},
      '{3'd4, 16'd4, 32'd3, 32'd15,    1'b1},
      '{3'd5, 16'd1, 32'd5, 32'd10,    1'b1},
      '{3'd6, 16'd0, 32'd1, 32'd65537, 1'b0},
      '{3'd7, 16'd2, 32'd1, 32'd65539, 1'b0}
   };

   logic        clk = 0, rst_n = 0;
   logic        sec_tick = 0, cfg_we = 0, cfg_en_in = 0, rld_we = 0, flag_clr = 0;
   logic [2:0]  cfg_sel_in = 0;
   logic [15:0] rld_in = 0;
   logic        en_q, wr_ok, wake_flag, wake_irq;
   logic [2:0]  sel_q;
   logic [15:0] reload_q;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_wakeup_timer dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cfg_we(cfg_we),
      .cfg_en_in(cfg_en_in), .cfg_sel_in(cfg_sel_in), .rld_we(rld_we),
      .rld_in(rld_in), .flag_clr(flag_clr), .en_q(en_q), .sel_q(sel_q),
      .reload_q(reload_q), .wr_ok(wr_ok), .wake_flag(wake_flag), .wake_irq(wake_irq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic configure(input logic [2:0] s, input logic [15:0] r);
      @(negedge clk);
      rld_we = 1; rld_in = r; cfg_we = 1; cfg_en_in = 0; cfg_sel_in = s;
      @(negedge clk);
      rld_we = 0; cfg_en_in = 1;          // enable write taken at next edge
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic disable_and_sync();
      @(negedge clk);
      cfg_we = 1; cfg_en_in = 0;
      @(negedge clk);
      cfg_we = 0;
      for (int k = 0; k < 64 && !wr_ok; k++) begin
         sec_tick = 1;
         @(negedge clk);
      end
      sec_tick = 0;
      flag_clr = 1;
      @(negedge clk);
      flag_clr = 0;
   endtask

   task automatic run_row(input int i);
      int n, first, second, limit, g;
      vec_t v = VEC[i];
      g = int'(v.gap);
      first = -1; second = -1;
      limit = int'(v.per) * 2 + 20;
      configure(v.sel, v.rld);
      n = 0;
      sec_tick = (g != 0) && (1 % g == 0);
      while (n < limit && (v.two ? second < 0 : first < 0)) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (wake_irq) begin
            if (first < 0) first = n; else if (second < 0) second = n;
         end
         sec_tick = (g != 0) && ((n + 1) % g == 0);
      end
      sec_tick = 0;
      if (v.sel < 4)
         chk(first == int'(v.per), "R2 first period", first, v.per);
      else if (v.sel < 6)
         chk(first == int'(v.per), "R3 first period", first, v.per);
      else
         chk(first == int'(v.per), "R4 extended period", first, v.per);
      if (v.two)
         chk(second - first == int'(v.per), "R5 reload period", second - first, v.per);
      chk(wake_flag == 1, "R5 sticky flag", wake_flag, 1);
      disable_and_sync();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(en_q == 0, "R1 enable", en_q, 0);
      chk(wr_ok == 1, "R1 wr_ok", wr_ok, 1);
      chk(wake_flag == 0 && wake_irq == 0, "R1 flag/irq", {wake_flag, wake_irq}, 0);
      chk(sel_q == 0 && reload_q == 16'hFFFF, "R1 config", reload_q, 16'hFFFF);
      rst_n = 1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) run_row(i);

      // R8: locked writes ignored, R7: wr_ok low while enabled
      configure(3'd4, 16'd7);
      chk(wr_ok == 0, "R7 wr_ok low enabled", wr_ok, 0);
      cfg_we = 1; cfg_en_in = 1; cfg_sel_in = 3'd1; rld_we = 1; rld_in = 16'h1234;
      @(negedge clk);
      cfg_we = 0; rld_we = 0;
      chk(sel_q == 3'd4, "R8 sel ignored", sel_q, 4);
      chk(reload_q == 16'd7, "R8 reload ignored", reload_q, 7);

      // R7: two strobes after disable
      cfg_we = 1; cfg_en_in = 0;
      @(negedge clk);
      cfg_we = 0;
      chk(wr_ok == 0, "R7 after disable", wr_ok, 0);
      sec_tick = 1; @(negedge clk); sec_tick = 0;
      chk(wr_ok == 0, "R7 after one tick", wr_ok, 0);
      @(negedge clk);
      chk(wr_ok == 0, "R7 no tick", wr_ok, 0);
      sec_tick = 1; @(negedge clk); sec_tick = 0;
      chk(wr_ok == 1, "R7 after two ticks", wr_ok, 1);

      // R9: disabled timer stays quiet (div2, reload 0)
      cfg_we = 1; cfg_en_in = 0; cfg_sel_in = 3'd3;
      @(negedge clk);
      cfg_we = 0;
      n = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (wake_irq) n++;
      end
      chk(n == 0, "R9 no irq disabled", n, 0);

      // R6: clear versus simultaneous expiry (code 3, reload 0: expiries at edges 2,4,6)
      configure(3'd3, 16'd0);
      @(posedge clk); @(posedge clk); @(posedge clk);   // edges 1..3
      @(negedge clk);
      flag_clr = 1;
      @(posedge clk);                                   // edge 4: expiry + clear
      @(negedge clk);
      chk(wake_flag == 1, "R6 expiry wins", wake_flag, 1);
      chk(wake_irq == 1, "R5 irq at expiry", wake_irq, 1);
      @(posedge clk);                                   // edge 5: clear only
      @(negedge clk);
      flag_clr = 0;
      chk(wake_flag == 0, "R6 clear", wake_flag, 0);
      chk(wake_irq == 0, "R5 irq one cycle", wake_irq, 0);
      disable_and_sync();
      chk(wr_ok == 1 && en_q == 0, "R7 resync", wr_ok, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule